// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Hazard Interlock

This block is the hazard logic of a five-stage in-order pipeline in which every instruction passes through fetch, decode, execute, memory and writeback at one clock per stage. It decides where each ALU operand of the instruction in execute comes from: the register file, the result leaving execute one cycle earlier (held in the execute/memory register), or the value in the memory/writeback register. The selects are worked out while the consumer is still in decode, by comparing its two source register numbers with the destinations of the instructions now in execute and memory. They are then registered, so they are ready at the start of the cycle in which the consumer executes.

When the instruction in execute is a load and its destination is a source of the instruction in decode, the loaded value cannot reach the consumer in time, even with bypassing. For that cycle the block holds the program counter and the fetch/decode register and turns the instruction entering execute into a bubble. On the next cycle the load has moved to memory and the normal bypass path from the memory/writeback register serves the consumer. A producer three instructions ahead needs no bypass, because the register file writes in the first half of a cycle and reads in the second.

Top module: `hazard_unit`

## Requirements
- R1: Each operand select uses 2'b00 for the register file value, 2'b10 for the execute/memory result and 2'b01 for the memory/writeback value; 2'b11 never appears. Operand A follows `id_src_a_i` and operand B follows `id_src_b_i`.
- R2: When the instruction in execute is valid, writes a register, is not a load, and its nonzero destination equals a source of the valid decode instruction, that operand's select is 2'b10 on the clock after it is presented.
- R3: When the instruction in memory is valid, writes a register, and its nonzero destination equals a source of the valid decode instruction, that operand's select is 2'b01 on the next clock, unless R2 applies to it.
- R4: When both the execute and memory producers match the same source, the execute producer (2'b10) wins.
- R5: Register 0 never causes bypassing or a stall. A producer whose write flag is low, or whose stage is not valid, also causes neither.
- R6: When a valid load in execute writes a nonzero destination that equals either source of the valid decode instruction, in that same cycle `pc_we_o` and `ifid_we_o` are 0 and `ex_bubble_o` is 1. In every other case they are 1, 1 and 0.
- R7: The selects registered during a stall cycle are 2'b00, because they belong to the bubble.
- R8: After a load-use stall, once the load has moved to memory, the held consumer gets select 2'b01 for the loaded register.
- R9: A source that matches neither the execute nor the memory destination gets 2'b00. This covers a producer three or more instructions ahead.
- R10: While `rst_ni` is low, both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| id_valid_i | input | 1 | Decode stage holds a real instruction |
| id_src_a_i | input | REG_W | First source register of the decode instruction |
| id_src_b_i | input | REG_W | Second source register of the decode instruction |
| ex_valid_i | input | 1 | Execute stage holds a real instruction |
| ex_dst_i | input | REG_W | Destination register of the execute instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction reads data memory |
| mem_valid_i | input | 1 | Memory stage holds a real instruction |
| mem_dst_i | input | REG_W | Destination register of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| fwd_a_o | output | 2 | Operand A source select for the execute instruction |
| fwd_b_o | output | 2 | Operand B source select for the execute instruction |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| ex_bubble_o | output | 1 | Clear the control of the instruction entering execute |

## Verification
The assertions check, on every cycle, that no select ever takes the unused code. They also check that a stall is raised only for a valid load, that the selects are cleared on the cycle after a stall, and that the execute producer wins when both producers match operand A. Register 0 is checked the same way: a zero operand-A source is never bypassed. The directed scenarios cover the rest, which depends on a cycle-by-cycle order of stage contents: the two-step load-use sequence (stall, then a memory/writeback bypass) and the individual gating by write flag and stage validity. They also confirm that a producer three instructions ahead leaves the register file selected.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    localparam int NUM_SRC = 2;

    typedef enum logic [1:0] {
        FWD_RF    = 2'b00,
        FWD_MEMWB = 2'b01,
        FWD_EXMEM = 2'b10
    } fwd_sel_e;

    typedef struct packed {
        fwd_sel_e [NUM_SRC-1:0] sel;
    } hz_state_t;

endpackage

// File: rtl/fwd_select.sv
module fwd_select
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             cons_valid_i,
    input  logic [REG_W-1:0] src_i,
    input  logic             near_valid_i,
    input  logic [REG_W-1:0] near_dst_i,
    input  logic             near_wr_i,
    input  logic             far_valid_i,
    input  logic [REG_W-1:0] far_dst_i,
    input  logic             far_wr_i,
    output fwd_sel_e         sel_o
);

    logic src_live;
    logic near_hit;
    logic far_hit;

    assign src_live = cons_valid_i && (src_i != '0);
    assign near_hit = src_live && near_valid_i && near_wr_i && (near_dst_i == src_i);
    assign far_hit  = src_live && far_valid_i && far_wr_i && (far_dst_i == src_i);

    always_comb begin
        if (near_hit) begin
            sel_o = FWD_EXMEM;
        end else if (far_hit) begin
            sel_o = FWD_MEMWB;
        end else begin
            sel_o = FWD_RF;
        end
    end

endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                            id_valid_i,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   src_i,
    input  logic                            ex_valid_i,
    input  logic [REG_W-1:0]                ex_dst_i,
    input  logic                            ex_wr_i,
    input  logic                            ex_load_i,
    output logic                            stall_o
);

    logic                 load_live;
    logic [NUM_SRC-1:0]   hit;

    assign load_live = ex_valid_i && ex_wr_i && ex_load_i && (ex_dst_i != '0);

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
        assign hit[k] = load_live && (src_i[k] == ex_dst_i);
    end

    assign stall_o = id_valid_i && (|hit);

endmodule

// File: rtl/hazard_unit.sv
module hazard_unit
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             id_valid_i,
    input  logic [REG_W-1:0] id_src_a_i,
    input  logic [REG_W-1:0] id_src_b_i,
    input  logic             ex_valid_i,
    input  logic [REG_W-1:0] ex_dst_i,
    input  logic             ex_wr_i,
    input  logic             ex_load_i,
    input  logic             mem_valid_i,
    input  logic [REG_W-1:0] mem_dst_i,
    input  logic             mem_wr_i,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o,
    output logic             pc_we_o,
    output logic             ifid_we_o,
    output logic             ex_bubble_o
);

    logic [NUM_SRC-1:0][REG_W-1:0] src_vec;
    fwd_sel_e [NUM_SRC-1:0]        nxt_sel;
    logic                          stall;
    hz_state_t                     st_d;
    hz_state_t                     st_q;

    assign src_vec = {id_src_b_i, id_src_a_i};

    // The producer now in execute becomes the execute/memory entry when the
    // consumer executes; the one now in memory becomes the memory/writeback entry.
    // A load in execute is not a bypass source: the interlock covers it.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        fwd_select #(.REG_W(REG_W)) u_fwd (
            .cons_valid_i (id_valid_i),
            .src_i        (src_vec[k]),
            .near_valid_i (ex_valid_i && !ex_load_i),
            .near_dst_i   (ex_dst_i),
            .near_wr_i    (ex_wr_i),
            .far_valid_i  (mem_valid_i),
            .far_dst_i    (mem_dst_i),
            .far_wr_i     (mem_wr_i),
            .sel_o        (nxt_sel[k])
        );
    end

    loaduse_detect #(.REG_W(REG_W)) u_ld (
        .id_valid_i (id_valid_i),
        .src_i      (src_vec),
        .ex_valid_i (ex_valid_i),
        .ex_dst_i   (ex_dst_i),
        .ex_wr_i    (ex_wr_i),
        .ex_load_i  (ex_load_i),
        .stall_o    (stall)
    );

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_SRC; k++) begin
            st_d.sel[k] = stall ? FWD_RF : nxt_sel[k];
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fwd_a_o     = st_q.sel[0];
    assign fwd_b_o     = st_q.sel[1];
    assign pc_we_o     = !stall;
    assign ifid_we_o   = !stall;
    assign ex_bubble_o = stall;

endmodule

// File: rtl/hazard_unit_chk.sv
module hazard_unit_chk #(
    parameter int REG_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             id_valid_i,
    input logic [REG_W-1:0] id_src_a_i,
    input logic             ex_valid_i,
    input logic [REG_W-1:0] ex_dst_i,
    input logic             ex_wr_i,
    input logic             ex_load_i,
    input logic [1:0]       fwd_a_o,
    input logic [1:0]       fwd_b_o,
    input logic             ex_bubble_o
);

    a_r1_no_unused_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fwd_a_o != 2'b11) && (fwd_b_o != 2'b11));

    a_r6_stall_needs_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ex_bubble_o |-> (ex_valid_i && ex_load_i && ex_wr_i && id_valid_i));

    a_r7_bubble_selects_rf: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ex_bubble_o && rst_ni) |=> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00));

    a_r4_near_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_valid_i && ex_valid_i && ex_wr_i && !ex_load_i && ex_dst_i != '0
         && id_src_a_i == ex_dst_i) |=> (fwd_a_o == 2'b10));

    a_r5_zero_not_bypassed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_src_a_i == '0) |=> (fwd_a_o == 2'b00));

endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .id_valid_i  (id_valid_i),
    .id_src_a_i  (id_src_a_i),
    .ex_valid_i  (ex_valid_i),
    .ex_dst_i    (ex_dst_i),
    .ex_wr_i     (ex_wr_i),
    .ex_load_i   (ex_load_i),
    .fwd_a_o     (fwd_a_o),
    .fwd_b_o     (fwd_b_o),
    .ex_bubble_o (ex_bubble_o)
);

// File: tb/hazard_unit_bench.sv
module hazard_unit_bench;

    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             id_valid = 1'b0;
    logic [REG_W-1:0] id_a = '0;
    logic [REG_W-1:0] id_b = '0;
    logic             ex_valid = 1'b0;
    logic [REG_W-1:0] ex_dst = '0;
    logic             ex_wr = 1'b0;
    logic             ex_load = 1'b0;
    logic             mem_valid = 1'b0;
    logic [REG_W-1:0] mem_dst = '0;
    logic             mem_wr = 1'b0;
    logic [1:0]       fwd_a;
    logic [1:0]       fwd_b;
    logic             pc_we;
    logic             ifid_we;
    logic             bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hazard_unit #(.REG_W(REG_W)) u_hazard_unit (
        .clk_i(clk), .rst_ni(rst_n),
        .id_valid_i(id_valid), .id_src_a_i(id_a), .id_src_b_i(id_b),
        .ex_valid_i(ex_valid), .ex_dst_i(ex_dst), .ex_wr_i(ex_wr), .ex_load_i(ex_load),
        .mem_valid_i(mem_valid), .mem_dst_i(mem_dst), .mem_wr_i(mem_wr),
        .fwd_a_o(fwd_a), .fwd_b_o(fwd_b),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .ex_bubble_o(bubble)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic present(input logic iv, input int a, input int b,
                           input logic ev, input int ed, input logic ew, input logic el,
                           input logic mv, input int md, input logic mw);
        @(negedge clk);
        id_valid = iv; id_a = REG_W'(a); id_b = REG_W'(b);
        ex_valid = ev; ex_dst = REG_W'(ed); ex_wr = ew; ex_load = el;
        mem_valid = mv; mem_dst = REG_W'(md); mem_wr = mw;
        #2;
    endtask

    // Stall outputs are combinational: checked in the presenting cycle.
    task automatic chk_stall(input string tag, input logic s);
        chk({tag, " pc_we"}, int'(pc_we), int'(!s));
        chk({tag, " ifid_we"}, int'(ifid_we), int'(!s));
        chk({tag, " bubble"}, int'(bubble), int'(s));
    endtask

    // Selects are registered: checked just after the next rising edge.
    task automatic chk_sel(input string tag, input int ea, input int eb);
        @(posedge clk);
        #2;
        chk({tag, " fwd_a"}, int'(fwd_a), ea);
        chk({tag, " fwd_b"}, int'(fwd_b), eb);
    endtask

    task automatic t_reset();
        present(1, 3, 4, 1, 3, 1, 0, 1, 4, 1);
        chk_sel("R10 reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_near();
        present(1, 5, 6, 1, 5, 1, 0, 0, 0, 0);
        chk_stall("R2 alu producer no stall", 0);
        chk_sel("R2 R1 exmem code 10", 2, 0);
        present(1, 8, 12, 1, 12, 1, 0, 0, 0, 0);
        chk_sel("R2 operand b", 0, 2);
    endtask

    task automatic t_far();
        present(1, 9, 6, 0, 6, 1, 0, 1, 6, 1);
        chk_sel("R3 R1 memwb code 01", 0, 1);
        present(1, 11, 11, 1, 2, 1, 0, 1, 11, 1);
        chk_sel("R3 both operands", 1, 1);
    endtask

    task automatic t_priority();
        present(1, 7, 7, 1, 7, 1, 0, 1, 7, 1);
        chk_sel("R4 both match", 2, 2);
        present(1, 7, 13, 1, 13, 1, 0, 1, 7, 1);
        chk_sel("R4 split", 1, 2);
    endtask

    task automatic t_gating();
        present(1, 0, 0, 1, 0, 1, 0, 1, 0, 1);
        chk_sel("R5 register zero", 0, 0);
        present(1, 3, 3, 1, 3, 0, 0, 1, 3, 0);
        chk_sel("R5 write flag low", 0, 0);
        present(1, 14, 15, 0, 14, 1, 0, 0, 15, 1);
        chk_sel("R5 producer invalid", 0, 0);
        present(1, 0, 4, 1, 0, 1, 1, 0, 0, 0);
        chk_stall("R5 load to register zero", 0);
        present(1, 4, 4, 1, 4, 0, 1, 0, 0, 0);
        chk_stall("R5 load without write", 0);
        present(0, 4, 4, 1, 4, 1, 1, 0, 0, 0);
        chk_stall("R6 decode invalid", 0);
    endtask

    task automatic t_loaduse();
        present(1, 9, 2, 1, 9, 1, 1, 0, 0, 0);
        chk_stall("R6 load-use on a", 1);
        chk_sel("R7 bubble selects", 0, 0);
        present(1, 9, 2, 0, 0, 0, 0, 1, 9, 1);
        chk_stall("R8 no second stall", 0);
        chk_sel("R8 loaded value from memwb", 1, 0);
        present(1, 1, 17, 1, 17, 1, 1, 0, 0, 0);
        chk_stall("R6 load-use on b", 1);
        present(1, 1, 18, 1, 17, 1, 1, 0, 0, 0);
        chk_stall("R6 load non-matching", 0);
    endtask

    task automatic t_third();
        present(1, 4, 10, 1, 1, 1, 0, 1, 2, 1);
        chk_sel("R9 producer beyond memory", 0, 0);
    endtask

    initial begin
        t_reset();
        t_near();
        t_far();
        t_priority();
        t_gating();
        t_loaduse();
        t_third();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule